// File: doc/BRIEF.md
# Video Inset Box-Average Decimator

This block shrinks a digitized video field into a small inset picture. Each output sample is the mean of a square box of input samples: f adjacent samples on each of f adjacent lines, where f is 2, 3 or 6. These factors give insets of one quarter, one ninth or one thirty-sixth of the source area. Luma is an unsigned 6-bit stream. The two colour-difference streams are signed 6-bit and are taken at one quarter of the luma rate. Each output sample leaves with a write strobe, a column index and a row index, ready to be stored in an external inset memory.

The inset is formed inside a fixed input window, set by the parameters `WIN_W` and `WIN_H`. The defaults are 576 luma samples per line and 252 lines per field. Line buffers inside the block hold the running vertical sums, one entry per output column.

Some sources deliver only one of the two colour components on each line, alternating from line to line. Vertical averaging then recombines the two components, but at half saturation. A configuration flag doubles the colour-difference results to correct for this. The shrink factor and this flag are both taken up at the start of a field, so a field is never processed with mixed settings.

Top module: `vinset_decim`

## Requirements
- R1: After reset, `y_we` and `c_we` stay low until a complete averaging box has been received inside a field.
- R2: `cfg_shrink` selects the factor f. The codes are 00 for 2, 01 for 3, 10 for 6, and 11 also for 2. For each box of f luma samples by f lines, `y_data` is floor((S + N/2) / N), where S is the box sum and N = f*f.
- R3: Chroma is taken only on cycles whose luma index within the line (starting at 0) is a multiple of 4. The inputs `in_u` and `in_v` are two's complement. Each chroma output averages a box of f chroma samples by f lines and rounds as floor((S + N/2) / N), with the floor taken toward minus infinity.
- R4: When the latched doubling flag is 1, each rounded chroma result is multiplied by 2 and saturated to the range -32..31. Luma is never scaled.
- R5: Samples with a luma index of `WIN_W` or more are ignored, and so are lines from index `WIN_H` onward in a field.
- R6: An incomplete box at the right edge of a line, or at the bottom of a field, produces no output.
- R7: Each completed box gives exactly one strobe. The column index counts boxes from 0 and restarts on every line. The row index counts completed rows of boxes from 0 and restarts at every field start.
- R8: `cfg_shrink` and `cfg_alt_chroma` are latched on the rising edge of `fv`. Changes made later have no effect until the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_shrink | input | 2 | Shrink factor code |
| cfg_alt_chroma | input | 1 | Doubling of colour-difference results |
| fv | input | 1 | Field valid; a rising edge starts a field |
| lv | input | 1 | Line valid; one luma sample per cycle while high |
| in_y | input | 6 | Luma sample, unsigned |
| in_u | input | 6 | First colour-difference sample, signed |
| in_v | input | 6 | Second colour-difference sample, signed |
| y_we | output | 1 | Luma output strobe |
| y_col | output | clog2(WIN_W/2+1) | Luma box column |
| y_row | output | clog2(WIN_H/2+1) | Box row |
| y_data | output | 6 | Averaged luma |
| c_we | output | 1 | Chroma output strobe |
| c_col | output | clog2(WIN_W/8+1) | Chroma box column |
| c_row | output | clog2(WIN_H/2+1) | Box row |
| c_u | output | 6 | Averaged first colour difference |
| c_v | output | 6 | Averaged second colour difference |

## Verification
A corrupted line-buffer entry or horizontal accumulator changes the data value of the next strobe for that column. The error shows at the latest at the end of the current row of boxes. A wrong line or box counter moves the row or column indices, or adds or drops a strobe, within one line. A latching fault in the configuration shows as a wrong output count, or as undoubled chroma, in the first field after the change.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

  typedef enum logic [1:0] {
    SHRINK_2  = 2'b00,
    SHRINK_3  = 2'b01,
    SHRINK_6  = 2'b10,
    SHRINK_2X = 2'b11
  } shrink_e;

  localparam int MAX_FACTOR = 6;
  localparam int SAMPLE_W   = 6;

  function automatic int fac_of(input logic [1:0] code);
    case (code)
      SHRINK_3: return 3;
      SHRINK_6: return 6;
      default:  return 2;
    endcase
  endfunction

endpackage

// File: rtl/vdec_ctrl.sv
module vdec_ctrl
  import vdec_pkg::*;
#(
  parameter int WIN_W = 576,
  parameter int WIN_H = 252,
  localparam int LW = $clog2(WIN_W + 1),
  localparam int HW = $clog2(WIN_H + 1),
  localparam int RW = $clog2(WIN_H / 2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_shrink,
  input  logic          cfg_dbl,
  input  logic          fv,
  input  logic          lv,
  output logic          sol,
  output logic          act_y,
  output logic          act_c,
  output logic          vfirst,
  output logic          vlast,
  output logic [RW-1:0] row,
  output logic [1:0]    shrink,
  output logic          dbl
);

  logic          fv_q, lv_q;
  logic [LW-1:0] lidx_q, lidx_d, lidx_eff;
  logic [HW-1:0] line_q, line_d;
  logic [2:0]    vph_q, vph_d;
  logic [RW-1:0] row_q, row_d;
  logic [1:0]    sh_q, sh_d;
  logic          dbl_q, dbl_d;
  logic          fstart, eol, line_in, col_in, act;

  always_comb begin
    fstart   = fv & ~fv_q;
    sol      = fv & lv & ~lv_q;
    eol      = fv & lv_q & ~lv;
    lidx_eff = sol ? '0 : lidx_q;
    line_in  = line_q < HW'(WIN_H);
    col_in   = lidx_eff < LW'(WIN_W);
    act      = fv & lv & line_in & col_in;
    act_y    = act;
    act_c    = act & (lidx_eff[1:0] == 2'b00);
    vfirst   = (vph_q == 3'd0);
    vlast    = (int'(vph_q) == fac_of(sh_q) - 1);
  end

  always_comb begin
    lidx_d = act ? lidx_eff + LW'(1) : lidx_eff;
    line_d = line_q;
    vph_d  = vph_q;
    row_d  = row_q;
    sh_d   = sh_q;
    dbl_d  = dbl_q;
    if (eol && line_in) begin
      line_d = line_q + HW'(1);
      if (vlast) begin
        vph_d = 3'd0;
        row_d = row_q + RW'(1);
      end else begin
        vph_d = vph_q + 3'd1;
      end
    end
    if (fstart) begin
      sh_d   = cfg_shrink;
      dbl_d  = cfg_dbl;
      line_d = '0;
      vph_d  = 3'd0;
      row_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      lv_q   <= 1'b0;
      lidx_q <= '0;
      line_q <= '0;
      vph_q  <= 3'd0;
      row_q  <= '0;
      sh_q   <= SHRINK_2;
      dbl_q  <= 1'b0;
    end else begin
      fv_q   <= fv;
      lv_q   <= lv;
      lidx_q <= lidx_d;
      line_q <= line_d;
      vph_q  <= vph_d;
      row_q  <= row_d;
      sh_q   <= sh_d;
      dbl_q  <= dbl_d;
    end
  end

  assign row    = row_q;
  assign shrink = sh_q;
  assign dbl    = dbl_q;

  // R8: settings move only on a field start
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fv && !fv_q) |=> ($stable(sh_q) && $stable(dbl_q)));

  // R7: line phase inside a box row stays below the factor
  a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vph_q) < fac_of(sh_q));

endmodule

// File: rtl/vdec_chan.sv
module vdec_chan
  import vdec_pkg::*;
#(
  parameter int LANES     = 1,
  parameter bit IS_SIGNED = 1'b0,
  parameter int DEPTH     = 288,
  parameter int RW        = 7,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW = $clog2(MAX_FACTOR * MAX_FACTOR * 64) + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           sol,
  input  logic [LANES-1:0][SAMPLE_W-1:0] din,
  input  logic                           vfirst,
  input  logic                           vlast,
  input  logic [RW-1:0]                  row,
  input  logic [1:0]                     shrink,
  input  logic                           dbl,
  output logic                           out_we,
  output logic [CW-1:0]                  out_col,
  output logic [RW-1:0]                  out_row,
  output logic [LANES-1:0][SAMPLE_W-1:0] out_data
);

  logic [2:0]    hph_q, hph_d, base_hph;
  logic [CW-1:0] col_q, col_d, base_col;
  logic [IW-1:0] lb_idx;
  logic          done, lb_we;
  logic          we_q, we_d, odbl_q, odbl_d;
  logic [CW-1:0] ocol_q, ocol_d;
  logic [RW-1:0] orow_q, orow_d;

  function automatic logic [SAMPLE_W-1:0] norm(input logic signed [SW-1:0] s,
                                               input logic [1:0] code,
                                               input logic       twice);
    int t, q, n;
    n = fac_of(code) * fac_of(code);
    t = int'(s) + n / 2 + (IS_SIGNED ? 32 * n : 0);
    case (code)
      SHRINK_3: q = t / 9;
      SHRINK_6: q = t / 36;
      default:  q = t / 4;
    endcase
    if (IS_SIGNED) begin
      q = q - 32;
      if (twice) q = q * 2;
      if (q > 31)  q = 31;
      if (q < -32) q = -32;
    end
    return q[SAMPLE_W-1:0];
  endfunction

  always_comb begin
    base_hph = sol ? 3'd0 : hph_q;
    base_col = sol ? '0 : col_q;
    done     = en && (int'(base_hph) == fac_of(shrink) - 1);
    lb_we    = done && (base_col < CW'(DEPTH));
    lb_idx   = (base_col < CW'(DEPTH)) ? IW'(base_col) : '0;
    hph_d    = base_hph;
    col_d    = base_col;
    if (en) begin
      if (done) begin
        hph_d = 3'd0;
        col_d = base_col + CW'(1);
      end else begin
        hph_d = base_hph + 3'd1;
      end
    end
    we_d   = done && vlast;
    ocol_d = we_d ? base_col : ocol_q;
    orow_d = we_d ? row : orow_q;
    odbl_d = we_d ? dbl : odbl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hph_q  <= 3'd0;
      col_q  <= '0;
      we_q   <= 1'b0;
      ocol_q <= '0;
      orow_q <= '0;
      odbl_q <= 1'b0;
    end else begin
      hph_q  <= hph_d;
      col_q  <= col_d;
      we_q   <= we_d;
      ocol_q <= ocol_d;
      orow_q <= orow_d;
      odbl_q <= odbl_d;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [SW-1:0] acc_q, acc_d, ext, hs, prev, vs;
    logic signed [SW-1:0] mem [DEPTH];
    logic [SAMPLE_W-1:0]  dat_q, dat_d;

    always_comb begin
      ext   = IS_SIGNED ? {{(SW-SAMPLE_W){din[k][SAMPLE_W-1]}}, din[k]}
                        : {{(SW-SAMPLE_W){1'b0}}, din[k]};
      hs    = (sol ? '0 : acc_q) + ext;
      prev  = vfirst ? '0 : mem[lb_idx];
      vs    = prev + hs;
      acc_d = sol ? '0 : acc_q;
      if (en) acc_d = done ? '0 : hs;
      dat_d = (done && vlast) ? norm(vs, shrink, dbl) : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        dat_q <= '0;
      end else begin
        acc_q <= acc_d;
        dat_q <= dat_d;
      end
    end

    always_ff @(posedge clk) begin
      if (lb_we) mem[lb_idx] <= vs;
    end

    assign out_data[k] = dat_q;

    if (IS_SIGNED) begin : g_chk
      // R4: a doubled, unsaturated result is even
      a_r4_dbl_even: assert property (@(posedge clk) disable iff (!rst_n)
        (we_q && odbl_q && dat_q != 6'h1f && dat_q != 6'h20) |-> (dat_q[0] == 1'b0));
    end
  end

  assign out_we  = we_q;
  assign out_col = ocol_q;
  assign out_row = orow_q;

  // R7: a box needs at least two samples, so strobes never come back to back
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |=> !out_we);

  // R5: columns stay inside the line buffer
  a_r5_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (int'(out_col) < DEPTH));

endmodule

// File: rtl/vinset_decim.sv
module vinset_decim
  import vdec_pkg::*;
#(
  parameter int WIN_W = 576,
  parameter int WIN_H = 252
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       cfg_shrink,
  input  logic                             cfg_alt_chroma,
  input  logic                             fv,
  input  logic                             lv,
  input  logic [5:0]                       in_y,
  input  logic [5:0]                       in_u,
  input  logic [5:0]                       in_v,
  output logic                             y_we,
  output logic [$clog2(WIN_W/2+1)-1:0]     y_col,
  output logic [$clog2(WIN_H/2+1)-1:0]     y_row,
  output logic [5:0]                       y_data,
  output logic                             c_we,
  output logic [$clog2(WIN_W/8+1)-1:0]     c_col,
  output logic [$clog2(WIN_H/2+1)-1:0]     c_row,
  output logic [5:0]                       c_u,
  output logic [5:0]                       c_v
);

  localparam int RW    = $clog2(WIN_H / 2 + 1);
  localparam int YDEP  = WIN_W / 2;
  localparam int CDEP  = WIN_W / 8;

  logic          sol, act_y, act_c, vfirst, vlast, dbl;
  logic [RW-1:0] row;
  logic [1:0]    shrink;
  logic [0:0][5:0] ydat;
  logic [1:0][5:0] cdat;

  vdec_ctrl #(.WIN_W(WIN_W), .WIN_H(WIN_H)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_shrink(cfg_shrink), .cfg_dbl(cfg_alt_chroma),
    .fv(fv), .lv(lv), .sol(sol), .act_y(act_y), .act_c(act_c),
    .vfirst(vfirst), .vlast(vlast), .row(row), .shrink(shrink), .dbl(dbl)
  );

  vdec_chan #(.LANES(1), .IS_SIGNED(1'b0), .DEPTH(YDEP), .RW(RW)) u_luma (
    .clk(clk), .rst_n(rst_n), .en(act_y), .sol(sol), .din(in_y),
    .vfirst(vfirst), .vlast(vlast), .row(row), .shrink(shrink), .dbl(1'b0),
    .out_we(y_we), .out_col(y_col), .out_row(y_row), .out_data(ydat)
  );

  vdec_chan #(.LANES(2), .IS_SIGNED(1'b1), .DEPTH(CDEP), .RW(RW)) u_chroma (
    .clk(clk), .rst_n(rst_n), .en(act_c), .sol(sol), .din({in_v, in_u}),
    .vfirst(vfirst), .vlast(vlast), .row(row), .shrink(shrink), .dbl(dbl),
    .out_we(c_we), .out_col(c_col), .out_row(c_row), .out_data(cdat)
  );

  assign y_data = ydat[0];
  assign c_u    = cdat[0];
  assign c_v    = cdat[1];

endmodule

// File: tb/vinset_decim_test.sv
`timescale 1ns/1ps
module vinset_decim_test;

  localparam int BW  = 48;
  localparam int BH  = 12;
  localparam int YCW = $clog2(BW/2+1);
  localparam int CCW = $clog2(BW/8+1);
  localparam int RW  = $clog2(BH/2+1);

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_shrink;
  logic cfg_alt_chroma, fv, lv;
  logic [5:0] in_y, in_u, in_v;
  logic y_we, c_we;
  logic [YCW-1:0] y_col;
  logic [CCW-1:0] c_col;
  logic [RW-1:0] y_row, c_row;
  logic [5:0] y_data, c_u, c_v;

  int vectors = 0;
  int miscompares = 0;
  int yq[$];
  int cq[$];

  always #2 clk = ~clk;

  vinset_decim #(.WIN_W(BW), .WIN_H(BH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_shrink(cfg_shrink), .cfg_alt_chroma(cfg_alt_chroma),
    .fv(fv), .lv(lv), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .y_we(y_we), .y_col(y_col), .y_row(y_row), .y_data(y_data),
    .c_we(c_we), .c_col(c_col), .c_row(c_row), .c_u(c_u), .c_v(c_v)
  );

  initial forever begin
    @(negedge clk);
    if (y_we) yq.push_back(int'(y_row) * 65536 + int'(y_col) * 256 + int'(y_data));
    if (c_we) cq.push_back(int'(c_row) * 1048576 + int'(c_col) * 4096 + int'(c_u) * 64 + int'(c_v));
  end

  function automatic int fac(input logic [1:0] code);
    return (code == 2'b01) ? 3 : (code == 2'b10) ? 6 : 2;
  endfunction

  // pattern sources; chroma values are signed -32..31
  function automatic int py(int s, int l, int c, bit k, int cy);
    return k ? cy : (s * 29 + l * 11 + c * 7 + ((l * c) % 5)) % 64;
  endfunction
  function automatic int pu(int s, int l, int c, bit k, int cu);
    return k ? cu : ((s * 13 + l * 5 + c * 3) % 64) - 32;
  endfunction
  function automatic int pv(int s, int l, int c, bit k, int cv);
    return k ? cv : ((s * 7 + l * 19 + c * 9 + 3) % 64) - 32;
  endfunction

  function automatic int rnd_s(int s, int n, bit twice);
    int t, q;
    t = s + n / 2;
    q = (t >= 0) ? t / n : -((-t + n - 1) / n);
    if (twice) q = q * 2;
    if (q > 31) q = 31;
    if (q < -32) q = -32;
    return q & 63;
  endfunction

  task automatic check(string req, int got, int exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_field(string req, logic [1:0] code, bit twice, int nl, int len,
                           int seed, bit k, int cy, int cu, int cv, bit late);
    int f, n, el, ec, cn, s0, s1, s2, ny, nc;
    int ey[$];
    int ec_q[$];
    yq.delete();
    cq.delete();
    @(negedge clk);
    cfg_shrink = code;
    cfg_alt_chroma = twice;
    fv = 1'b1;
    @(negedge clk);
    if (late) begin
      cfg_shrink = 2'b10;
      cfg_alt_chroma = ~twice;
    end
    repeat (2) @(negedge clk);
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < len; c++) begin
        lv = 1'b1;
        in_y = 6'(py(seed, l, c, k, cy));
        in_u = 6'(pu(seed, l, c, k, cu));
        in_v = 6'(pv(seed, l, c, k, cv));
        @(negedge clk);
      end
      lv = 1'b0;
      repeat (3) @(negedge clk);
    end
    fv = 1'b0;
    repeat (4) @(negedge clk);
    f = fac(code);
    n = f * f;
    el = (nl < BH) ? nl : BH;
    ec = (len < BW) ? len : BW;
    cn = (ec + 3) / 4;
    for (int r = 0; r < el / f; r++) begin
      for (int g = 0; g < ec / f; g++) begin
        s0 = 0;
        for (int a = 0; a < f; a++)
          for (int b = 0; b < f; b++) s0 += py(seed, r * f + a, g * f + b, k, cy);
        ey.push_back(r * 65536 + g * 256 + (s0 + n / 2) / n);
      end
      for (int g = 0; g < cn / f; g++) begin
        s1 = 0;
        s2 = 0;
        for (int a = 0; a < f; a++)
          for (int b = 0; b < f; b++) begin
            s1 += pu(seed, r * f + a, (g * f + b) * 4, k, cu);
            s2 += pv(seed, r * f + a, (g * f + b) * 4, k, cv);
          end
        ec_q.push_back(r * 1048576 + g * 4096 + rnd_s(s1, n, twice) * 64 + rnd_s(s2, n, twice));
      end
    end
    ny = yq.size();
    nc = cq.size();
    check({req, " luma count"}, ny, ey.size());
    check({req, " chroma count"}, nc, ec_q.size());
    for (int i = 0; i < ey.size() && i < ny; i++) check({req, " luma row/col/data"}, yq[i], ey[i]);
    for (int i = 0; i < ec_q.size() && i < nc; i++) check({req, " chroma row/col/u/v"}, cq[i], ec_q[i]);
  endtask

  task automatic t_reset;
    int hits = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (y_we || c_we) hits++;
    end
    check("R1 idle strobes", hits, 0);
    check("R1 y_we", int'(y_we), 0);
    check("R1 c_we", int'(c_we), 0);
  endtask

  task automatic t_factors;
    run_field("R2 R3 R7 f2", 2'b00, 1'b0, BH, BW, 1, 1'b0, 0, 0, 0, 1'b0);
    run_field("R2 R3 R7 f3", 2'b01, 1'b0, BH, BW, 2, 1'b0, 0, 0, 0, 1'b0);
    run_field("R2 R3 R7 f6", 2'b10, 1'b0, BH, BW, 3, 1'b0, 0, 0, 0, 1'b0);
    run_field("R2 code11", 2'b11, 1'b0, BH, BW, 4, 1'b0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_double;
    run_field("R4 pattern", 2'b00, 1'b1, BH, BW, 5, 1'b0, 0, 0, 0, 1'b0);
    run_field("R4 saturate", 2'b01, 1'b1, 6, BW, 0, 1'b1, 40, 20, -20, 1'b0);
    run_field("R4 small", 2'b10, 1'b1, 6, BW, 0, 1'b1, 63, -7, 9, 1'b0);
  endtask

  task automatic t_window;
    run_field("R5 oversize", 2'b01, 1'b0, BH + 3, BW + 8, 6, 1'b0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_partial;
    run_field("R6 f6 edges", 2'b10, 1'b0, 11, 46, 7, 1'b0, 0, 0, 0, 1'b0);
    run_field("R6 f2 edges", 2'b00, 1'b0, 5, 47, 8, 1'b0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_late_cfg;
    run_field("R8 late change", 2'b00, 1'b0, BH, BW, 9, 1'b0, 0, 0, 0, 1'b1);
    run_field("R8 next field", 2'b01, 1'b1, BH, BW, 10, 1'b0, 0, 0, 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_shrink = 2'b00;
    cfg_alt_chroma = 1'b0;
    fv = 1'b0;
    lv = 1'b0;
    in_y = '0;
    in_u = '0;
    in_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_factors();
    t_double();
    t_window();
    t_partial();
    t_late_cfg();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule